// File: doc/BRIEF.md
# Four-State Snooping Cache Line Controller

This block keeps one small private write-back cache coherent with its peers on a shared snooping bus. It holds a direct-mapped array of single-word lines, each tagged with one of four coherence states: Modified (sole copy, dirty), Exclusive (sole copy, clean), Shared (one of possibly several clean copies) or Invalid. Processor reads and writes are served from the array when the line state allows it. Otherwise the controller wins the bus through a request/grant pair and issues a bus read, a bus read-exclusive, or, when a dirty line has to make room, a write-back of that line.

A bus read samples the wired-OR shared line at the same moment as the fill data. If no peer claims a copy, the line fills as Exclusive, and a later processor write to it upgrades to Modified with no bus traffic at all. At the same time the controller watches transactions from other masters. On a hit it drives its contribution to the shared line, supplies data when it holds the only copy, and downgrades or invalidates the line.

A bus transaction completes in the single cycle in which `bus_req` and `bus_gnt` are both high. Fill data and the shared line are sampled at that clock edge. Snooped transactions arrive only while this block does not hold the grant. The snoop response is combinational in the snoop cycle, and the state change takes effect at the following edge.

Top module: `mesi_snoop_cache`

## Requirements
- R1: After a synchronous active-low reset every line is Invalid, `cpu_ready` is 1, and `cpu_done` and `bus_req` are 0. A snooped read of any address then sees no copy (`snp_shared`=0, `snp_supply`=0).
- R2: A read miss issues one bus read (`bus_cmd`=1) and returns the fill data on `cpu_rdata` with a one-cycle `cpu_done`. The line is filled Exclusive when `bus_shared_i` was 0 at the grant edge and Shared when it was 1.
- R3: A read that hits a line in Modified, Exclusive or Shared returns the stored word with no bus request.
- R4: A write that hits an Exclusive line completes with no bus request and leaves the line Modified, holding the new word.
- R5: A write that hits a Shared line or misses issues one bus read-exclusive (`bus_cmd`=2) and leaves the line Modified, holding the write data.
- R6: A snooped read (`snp_cmd`=0) that hits a Modified line asserts `snp_shared`, `snp_supply` and `snp_dirty` with the line word on `snp_data`. A hit on an Exclusive line asserts `snp_shared` and `snp_supply` with `snp_dirty`=0. Both lines become Shared.
- R7: A snooped read-exclusive (`snp_cmd`=1) that hits a Modified line supplies the word with `snp_dirty`=1. A hit in any state leaves the line Invalid and does not assert `snp_shared`.
- R8: A snooped read that hits a Shared line asserts `snp_shared`, does not supply data, and leaves the line Shared.
- R9: A miss whose slot holds a Modified line with another tag first issues a write-back (`bus_cmd`=3) carrying the victim address and word, and only then issues the request for the new address. A clean victim is dropped with no bus traffic. The slot index is the low `IDX_W` address bits.
- R10: While a bus request waits for `bus_gnt`, `bus_req` stays high, `cpu_ready` stays 0 and no `cpu_done` is given. A new processor request is accepted only while `cpu_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor request strobe, taken while cpu_ready is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant; req and gnt both high completes a transaction |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 write-back |
| bus_addr | output | ADDR_W | Address of the issued transaction |
| bus_wdata | output | DATA_W | Word carried by a write-back |
| bus_rdata | input | DATA_W | Fill word, sampled at the grant edge |
| bus_shared_i | input | 1 | Wired-OR shared line, sampled at a read's grant edge |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 1 | Snooped kind: 0 read, 1 read-exclusive |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache's contribution to the wired-OR shared line |
| snp_supply | output | 1 | This cache drives the word for the snooped transaction |
| snp_dirty | output | 1 | The supplied word is a flush of dirty data |
| snp_data | output | DATA_W | Supplied word |

## Verification
A processor request strobed before edge E0 is latched at E0. Its bus command is visible at the following falling edge, and a hit or a granted single transaction raises `cpu_done` one edge later. Each write-back in front of the request adds one cycle, and each cycle without a grant adds one more. The bench therefore does not wait a fixed number of cycles. It polls at falling edges, records every granted command with its address and word, and reads the result in the cycle `cpu_done` is seen. Snoop responses are sampled 1 ns after the snoop is driven in the same cycle. Line states are inferred from later transactions at the ports, so a silent upgrade shows up as a dirty supply on the next snoop.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the snooping cache controller.
// Line states, bus commands issued by this cache, and snooped command kinds.
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE  = 2'd0,
        BC_READ  = 2'd1,
        BC_READX = 2'd2,
        BC_WBACK = 2'd3
    } bus_cmd_e;

    localparam logic SN_READ  = 1'b0;
    localparam logic SN_READX = 1'b1;
endpackage

// File: rtl/mesi_line_array.sv
`timescale 1ns/1ps
// Direct-mapped line store: state, tag and one data word per line.
// Two read ports (processor side, snoop side), one full write port from the
// processor side and one state-only write port from the snoop side.
// Assumes both write ports never target the same line in one cycle; port A wins if they do.
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [1:0]        ra_st,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [1:0]        rb_st,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic [1:0]        wa_st,
    input  logic [TAG_W-1:0]  wa_tag,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [1:0]        wb_st
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0][1:0]        st_all;
    logic [LINES-1:0][TAG_W-1:0]  tag_all;
    logic [LINES-1:0][DATA_W-1:0] data_all;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [1:0]        st_q;
        logic [TAG_W-1:0]  tag_q;
        logic [DATA_W-1:0] data_q;
        logic              hit_a;
        logic              hit_b;

        assign hit_a = wa_en && (wa_idx == IDX_W'(g));
        assign hit_b = wb_en && (wb_idx == IDX_W'(g));

        // Line state: reset to Invalid, processor port first, then snoop port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= ST_I;
            end else if (hit_a) begin
                st_q <= wa_st;
            end else if (hit_b) begin
                st_q <= wb_st;
            end
        end

        // Tag and data: only the processor port writes them.
        always_ff @(posedge clk) begin
            if (hit_a) begin
                tag_q  <= wa_tag;
                data_q <= wa_data;
            end
        end

        assign st_all[g]   = st_q;
        assign tag_all[g]  = tag_q;
        assign data_all[g] = data_q;
    end

    // Read ports are plain muxes over the line vectors.
    assign ra_st   = st_all[ra_idx];
    assign ra_tag  = tag_all[ra_idx];
    assign ra_data = data_all[ra_idx];
    assign rb_st   = st_all[rb_idx];
    assign rb_tag  = tag_all[rb_idx];
    assign rb_data = data_all[rb_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
`timescale 1ns/1ps
// Combinational responder for transactions of other masters.
// Looks at the addressed line and yields the wired-OR shared contribution,
// the data-supply decision and the state update applied at the next edge.
// Assumes snoops arrive only while this cache does not own the bus.
module mesi_snoop_resp
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  logic              snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [1:0]        ln_st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              hit,
    output logic              shared_o,
    output logic              supply_o,
    output logic              dirty_o,
    output logic [DATA_W-1:0] data_o,
    output logic              upd_en,
    output logic [1:0]        upd_st
);
    assign hit = snp_valid && (ln_st != ST_I) && (ln_tag == snp_tag);

    // Decide response and next state from the snooped kind and the line state.
    always_comb begin
        shared_o = 1'b0;
        supply_o = 1'b0;
        dirty_o  = 1'b0;
        upd_en   = 1'b0;
        upd_st   = ST_I;
        if (hit) begin
            if (snp_cmd == SN_READ) begin
                shared_o = 1'b1;
                unique case (ln_st)
                    ST_M: begin supply_o = 1'b1; dirty_o = 1'b1; upd_en = 1'b1; upd_st = ST_S; end
                    ST_E: begin supply_o = 1'b1; upd_en = 1'b1; upd_st = ST_S; end
                    default: ;
                endcase
            end else begin
                upd_en = 1'b1;
                upd_st = ST_I;
                if (ln_st == ST_M) begin
                    supply_o = 1'b1;
                    dirty_o  = 1'b1;
                end
            end
        end
    end

    assign data_o = supply_o ? ln_data : '0;
endmodule

// File: rtl/mesi_cpu_fsm.sv
`timescale 1ns/1ps
// Processor-side sequencer: latches one request, serves hits locally,
// otherwise requests the bus for a write-back of a dirty victim and then
// a read or read-exclusive, and writes the result into the line store.
// Assumes a granted transaction completes at the grant edge.
module mesi_cpu_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic                    cpu_done,
    output logic [DATA_W-1:0]       cpu_rdata,
    input  logic                    snp_valid,
    input  logic                    bus_gnt,
    input  logic                    bus_shared_i,
    input  logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_req,
    output logic [1:0]              bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_wdata,
    output logic [IDX_W-1:0]        req_idx,
    input  logic [1:0]              ln_st,
    input  logic [ADDR_W-IDX_W-1:0] ln_tag,
    input  logic [DATA_W-1:0]       ln_data,
    output logic                    wa_en,
    output logic [1:0]              wa_st,
    output logic [ADDR_W-IDX_W-1:0] wa_tag,
    output logic [DATA_W-1:0]       wa_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              busy_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    logic [TAG_W-1:0]  req_tag;
    logic              line_hit;
    logic              victim_dirty;
    logic              local_cand;
    logic              local_done;
    logic              txn;
    logic              finish;
    logic [DATA_W-1:0] result;

    assign req_tag = addr_q[ADDR_W-1:IDX_W];
    assign req_idx = addr_q[IDX_W-1:0];

    // Classify the latched request against the addressed line.
    always_comb begin
        line_hit     = (ln_st != ST_I) && (ln_tag == req_tag);
        victim_dirty = (ln_st == ST_M) && (ln_tag != req_tag);
        local_cand   = line_hit && (!we_q || ln_st == ST_M || ln_st == ST_E);
        local_done   = busy_q && local_cand && !snp_valid;
    end

    // Bus master side: request and command for the current step.
    always_comb begin
        bus_req   = busy_q && !local_cand;
        bus_cmd   = BC_NONE;
        bus_addr  = addr_q;
        bus_wdata = '0;
        if (bus_req) begin
            if (victim_dirty) begin
                bus_cmd   = BC_WBACK;
                bus_addr  = {ln_tag, req_idx};
                bus_wdata = ln_data;
            end else begin
                bus_cmd = we_q ? BC_READX : BC_READ;
            end
        end
    end

    assign txn    = bus_req && bus_gnt;
    assign finish = local_done || (txn && !victim_dirty);

    // Line-store update for a local write hit or a completed transaction.
    always_comb begin
        wa_en   = 1'b0;
        wa_st   = ST_I;
        wa_tag  = req_tag;
        wa_data = wdata_q;
        result  = ln_data;
        if (local_done) begin
            wa_en  = we_q;
            wa_st  = ST_M;
            result = we_q ? wdata_q : ln_data;
        end else if (txn) begin
            wa_en = 1'b1;
            if (victim_dirty) begin
                wa_st   = ST_I;
                wa_tag  = ln_tag;
                wa_data = ln_data;
            end else if (we_q) begin
                wa_st  = ST_M;
                result = wdata_q;
            end else begin
                wa_st   = bus_shared_i ? ST_S : ST_E;
                wa_data = bus_rdata;
                result  = bus_rdata;
            end
        end
    end

    // Request latch and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= finish;
            if (finish) begin
                rdata_q <= result;
            end
            if (!busy_q && cpu_req) begin
                busy_q  <= 1'b1;
                we_q    <= cpu_we;
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
            end else if (finish) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign cpu_ready = !busy_q;
    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req); // R10
    AST_NO_DONE_UNGRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> !cpu_done); // R10
    AST_FILL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (txn && bus_cmd == BC_READ) |=> (ln_st == ($past(bus_shared_i) ? ST_S : ST_E))); // R2
    AST_READX_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (txn && bus_cmd == BC_READX) |=> (ln_st == ST_M)); // R5
    AST_WBACK_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (txn && bus_cmd == BC_WBACK) |=> (!cpu_done && bus_cmd != BC_WBACK)); // R9
    AST_SILENT_UPGRADE: assert property (@(posedge clk) disable iff (!rst_n)
        (local_done && we_q) |=> (ln_st == ST_M && ln_data == $past(wdata_q))); // R4
endmodule

// File: rtl/mesi_snoop_cache.sv
`timescale 1ns/1ps
// Four-state snooping controller for a direct-mapped, single-word-line
// write-back cache. Joins the line store, the processor sequencer and the
// snoop responder. Assumes other masters' transactions (snp_valid) appear
// only while this cache does not hold bus_gnt.
module mesi_snoop_cache
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared_i,
    input  logic              snp_valid,
    input  logic              snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic              snp_dirty,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  req_idx;
    logic [1:0]        ra_st, rb_st;
    logic [TAG_W-1:0]  ra_tag, rb_tag;
    logic [DATA_W-1:0] ra_data, rb_data;
    logic              wa_en;
    logic [1:0]        wa_st;
    logic [TAG_W-1:0]  wa_tag;
    logic [DATA_W-1:0] wa_data;
    logic              sn_hit;
    logic              sn_upd_en;
    logic [1:0]        sn_upd_st;
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;

    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    mesi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (req_idx),
        .ra_st   (ra_st),
        .ra_tag  (ra_tag),
        .ra_data (ra_data),
        .rb_idx  (snp_idx),
        .rb_st   (rb_st),
        .rb_tag  (rb_tag),
        .rb_data (rb_data),
        .wa_en   (wa_en),
        .wa_idx  (req_idx),
        .wa_st   (wa_st),
        .wa_tag  (wa_tag),
        .wa_data (wa_data),
        .wb_en   (sn_upd_en),
        .wb_idx  (snp_idx),
        .wb_st   (sn_upd_st)
    );

    mesi_cpu_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_ready    (cpu_ready),
        .cpu_done     (cpu_done),
        .cpu_rdata    (cpu_rdata),
        .snp_valid    (snp_valid),
        .bus_gnt      (bus_gnt),
        .bus_shared_i (bus_shared_i),
        .bus_rdata    (bus_rdata),
        .bus_req      (bus_req),
        .bus_cmd      (bus_cmd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .req_idx      (req_idx),
        .ln_st        (ra_st),
        .ln_tag       (ra_tag),
        .ln_data      (ra_data),
        .wa_en        (wa_en),
        .wa_st        (wa_st),
        .wa_tag       (wa_tag),
        .wa_data      (wa_data)
    );

    mesi_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .snp_tag   (snp_tag),
        .ln_st     (rb_st),
        .ln_tag    (rb_tag),
        .ln_data   (rb_data),
        .hit       (sn_hit),
        .shared_o  (snp_shared),
        .supply_o  (snp_supply),
        .dirty_o   (snp_dirty),
        .data_o    (snp_data),
        .upd_en    (sn_upd_en),
        .upd_st    (sn_upd_st)
    );

    AST_SNP_READX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_hit && snp_cmd == SN_READX) |=> (snp_idx != $past(snp_idx) || rb_st == ST_I)); // R7
    AST_SNP_SHARED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_hit && snp_cmd == SN_READ && rb_st == ST_S) |=> (snp_idx != $past(snp_idx) || rb_st == ST_S)); // R8
    AST_SNP_READ_DOWNGRADE: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_hit && snp_cmd == SN_READ) |=> (snp_idx != $past(snp_idx) || rb_st == ST_S)); // R6
    AST_SNP_NOT_WHILE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !(bus_req && bus_gnt)); // R10
endmodule

// File: tb/mesi_snoop_cache_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, then directed tests.
module mesi_snoop_cache_tb_top;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 3;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_ready;
    logic              cpu_done;
    logic [DATA_W-1:0] cpu_rdata;
    logic              bus_req;
    logic              bus_gnt = 1'b1;
    logic [1:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic              bus_shared_i = 1'b0;
    logic              snp_valid = 1'b0;
    logic              snp_cmd = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_shared;
    logic              snp_supply;
    logic              snp_dirty;
    logic [DATA_W-1:0] snp_data;

    always #2.5 clk = ~clk;

    mesi_snoop_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_shared_i(bus_shared_i),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_dirty(snp_dirty),
        .snp_data(snp_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Observations filled by the operation tasks.
    logic [1:0]        o_cmd;
    int                o_n;
    logic [DATA_W-1:0] o_rd;
    logic [DATA_W-1:0] o_wb;
    logic [ADDR_W-1:0] o_wa;
    logic              o_done;
    logic              o_sh, o_sup, o_dirty;
    logic [DATA_W-1:0] o_sd;

    // op: 0 cpu read, 1 cpu write, 2 snoop read, 3 snoop read-exclusive
    typedef struct packed {
        logic [1:0]        op;
        logic [7:0]        addr;
        logic [15:0]       data;
        logic              shr;
        logic [1:0]        ecmd;
        logic [1:0]        en;
        logic [15:0]       edata;
        logic [15:0]       ewb;
        logic [7:0]        ewa;
        logic              esh;
        logic              esup;
        logic              edirty;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'h11, 16'hA001, 1'b0, 2'd1, 2'd1, 16'hA001, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 fill E
        '{2'd2, 8'h11, 16'h0,    1'b0, 2'd0, 2'd0, 16'hA001, 16'h0, 8'h0, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 E supplies clean
        '{2'd2, 8'h11, 16'h0,    1'b0, 2'd0, 2'd0, 16'h0,    16'h0, 8'h0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 S kept
        '{2'd1, 8'h11, 16'hB002, 1'b0, 2'd2, 2'd1, 16'h0,    16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 S write
        '{2'd0, 8'h11, 16'h0,    1'b0, 2'd0, 2'd0, 16'hB002, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 M hit
        '{2'd2, 8'h11, 16'h0,    1'b0, 2'd0, 2'd0, 16'hB002, 16'h0, 8'h0, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 M flush
        '{2'd3, 8'h11, 16'h0,    1'b0, 2'd0, 2'd0, 16'h0,    16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 S invalidated
        '{2'd0, 8'h11, 16'hC003, 1'b1, 2'd1, 2'd1, 16'hC003, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 fill S
        '{2'd2, 8'h11, 16'h0,    1'b0, 2'd0, 2'd0, 16'h0,    16'h0, 8'h0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 no supply from S
        '{2'd1, 8'h22, 16'h1234, 1'b0, 2'd2, 2'd1, 16'h0,    16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 write miss
        '{2'd3, 8'h22, 16'h0,    1'b0, 2'd0, 2'd0, 16'h1234, 16'h0, 8'h0, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 M flush, I
        '{2'd0, 8'h23, 16'hD004, 1'b0, 2'd1, 2'd1, 16'hD004, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 fill E
        '{2'd1, 8'h23, 16'hD005, 1'b0, 2'd0, 2'd0, 16'h0,    16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 silent
        '{2'd2, 8'h23, 16'h0,    1'b0, 2'd0, 2'd0, 16'hD005, 16'h0, 8'h0, 1'b1, 1'b1, 1'b1, 4'd4},  // R4 now M
        '{2'd1, 8'h2C, 16'hE006, 1'b0, 2'd2, 2'd1, 16'h0,    16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
        '{2'd0, 8'h34, 16'hF007, 1'b0, 2'd3, 2'd2, 16'hF007, 16'hE006, 8'h2C, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 dirty victim
        '{2'd0, 8'h3B, 16'h0B0B, 1'b1, 2'd1, 2'd1, 16'h0B0B, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 clean victim
        '{2'd2, 8'h2C, 16'h0,    1'b0, 2'd0, 2'd0, 16'h0,    16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 evicted gone
        '{2'd2, 8'h23, 16'h0,    1'b0, 2'd0, 2'd0, 16'h0,    16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 clean dropped
        '{2'd0, 8'h34, 16'h0,    1'b0, 2'd0, 2'd0, 16'hF007, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 4'd3}   // R3 E hit
    };

    task automatic chk(input bit ok, input string what, input int req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Processor request: strobe, then poll falling edges until completion.
    task automatic cpu_op(input logic we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input logic shr);
        o_cmd = 2'd0; o_n = 0; o_rd = '0; o_wb = '0; o_wa = '0; o_done = 1'b0;
        bus_rdata = d;
        bus_shared_i = shr;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (bus_req && bus_gnt) begin
                if (o_n == 0) o_cmd = bus_cmd;
                if (bus_cmd == 2'd3) begin o_wb = bus_wdata; o_wa = bus_addr; end
                o_n++;
            end
            if (cpu_done) begin
                o_rd = cpu_rdata;
                o_done = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // Snooped transaction of another master, one cycle, bus not granted to the DUT.
    task automatic snoop_op(input logic kind, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        bus_gnt = 1'b0;
        snp_valid = 1'b1; snp_cmd = kind; snp_addr = a;
        #1;
        o_sh = snp_shared; o_sup = snp_supply; o_dirty = snp_dirty; o_sd = snp_data;
        @(negedge clk);
        snp_valid = 1'b0;
        bus_gnt = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state at the ports
        chk(cpu_ready == 1'b1, "ready after reset", 1, 32'(cpu_ready), 32'd1);
        chk(cpu_done == 1'b0 && bus_req == 1'b0, "done/req after reset", 1,
            {30'd0, cpu_done, bus_req}, 32'd0);
        snoop_op(1'b0, 8'h11);
        chk(o_sh == 1'b0 && o_sup == 1'b0, "no copy after reset", 1, {30'd0, o_sh, o_sup}, 32'd0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            if (VEC[v].op[1] == 1'b0) begin
                cpu_op(VEC[v].op[0], VEC[v].addr, VEC[v].data, VEC[v].shr);
                chk(o_done == 1'b1, $sformatf("v%0d completion", v), int'(VEC[v].req), 32'(o_done), 32'd1);
                chk(o_n == int'(VEC[v].en), $sformatf("v%0d bus count", v), int'(VEC[v].req),
                    32'(o_n), 32'(VEC[v].en));
                if (VEC[v].en != 2'd0)
                    chk(o_cmd == VEC[v].ecmd, $sformatf("v%0d first cmd", v), int'(VEC[v].req),
                        32'(o_cmd), 32'(VEC[v].ecmd));
                if (VEC[v].op[0] == 1'b0)
                    chk(o_rd == VEC[v].edata, $sformatf("v%0d read data", v), int'(VEC[v].req),
                        32'(o_rd), 32'(VEC[v].edata));
                if (VEC[v].ecmd == 2'd3) begin
                    chk(o_wb == VEC[v].ewb, $sformatf("v%0d writeback word", v), int'(VEC[v].req),
                        32'(o_wb), 32'(VEC[v].ewb));
                    chk(o_wa == VEC[v].ewa, $sformatf("v%0d writeback addr", v), int'(VEC[v].req),
                        32'(o_wa), 32'(VEC[v].ewa));
                end
            end else begin
                snoop_op(VEC[v].op[0], VEC[v].addr);
                chk({o_sh, o_sup, o_dirty} == {VEC[v].esh, VEC[v].esup, VEC[v].edirty},
                    $sformatf("v%0d snoop flags", v), int'(VEC[v].req),
                    {29'd0, o_sh, o_sup, o_dirty}, {29'd0, VEC[v].esh, VEC[v].esup, VEC[v].edirty});
                if (VEC[v].esup)
                    chk(o_sd == VEC[v].edata, $sformatf("v%0d snoop data", v), int'(VEC[v].req),
                        32'(o_sd), 32'(VEC[v].edata));
            end
        end

        // R10: request waits for grant
        bus_gnt = 1'b0;
        bus_rdata = 16'h5555;
        bus_shared_i = 1'b0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h45; cpu_wdata = '0;
        @(negedge clk);
        cpu_req = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(bus_req == 1'b1 && cpu_done == 1'b0 && cpu_ready == 1'b0, "held without grant", 10,
                {29'd0, bus_req, cpu_done, cpu_ready}, 32'h4);
            @(negedge clk);
        end
        bus_gnt = 1'b1;
        @(negedge clk);
        chk(cpu_done == 1'b1 && cpu_rdata == 16'h5555, "done after grant", 10,
            {15'd0, cpu_done, cpu_rdata}, {15'd0, 1'b1, 16'h5555});

        // R7: read-exclusive snoop on an Exclusive line, no supply, then gone
        cpu_op(1'b0, 8'h47, 16'h7777, 1'b0);
        snoop_op(1'b1, 8'h47);
        chk(o_sh == 1'b0 && o_sup == 1'b0, "readx on E", 7, {30'd0, o_sh, o_sup}, 32'd0);
        snoop_op(1'b0, 8'h47);
        chk(o_sh == 1'b0, "E line invalid after readx", 7, 32'(o_sh), 32'd0);

        // R1: reset while lines are valid clears them
        cpu_op(1'b1, 8'h46, 16'h6666, 1'b0);
        do_reset();
        snoop_op(1'b0, 8'h46);
        chk(o_sh == 1'b0 && o_sup == 1'b0, "lines cleared by reset", 1, {30'd0, o_sh, o_sup}, 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule